// File: doc/BRIEF.md
# Scintillator Layer Coincidence Counter

This block forms per-counter coincidences between two concentric rings of barrel time-of-flight counters. Each clock it takes one discriminated hit vector per ring. An inner-ring counter is accepted when it fires together with at least one of the two outer-ring counters that sit beside it. Both rings are closed, so neighbour indices wrap around.

From the accepted counters the block forms a population count and three topology flags for the global trigger decision:
- at least one accepted counter;
- at least two accepted counters;
- a back-to-back pair, meaning two accepted counters on roughly opposite sides of the ring.

The logic is a three-stage pipeline. It accepts a new pair of hit vectors on every clock and has no dead time. Ring size, the back-to-back tolerance and the adder arrangement of the population count are parameters.

Top module: `tof_coinc_counter`

## Requirements
- R1: While reset is asserted, and on the first clocks after it is released, count_o is 0 and any_o, multi_o and b2b_o are 0.
- R2: Inner counter i is accepted exactly when inner_hit_i[i] is 1 and at least one of outer_hit_i[i-1] and outer_hit_i[i+1] is 1. The outer counter with the same index i does not take part in the pairing.
- R3: Neighbour indices wrap around the ring. Inner counter 0 pairs with outer counters N_CNT-1 and 1. Inner counter N_CNT-1 pairs with outer counters N_CNT-2 and 0.
- R4: count_o equals the number of accepted inner counters. Its range is 0 to N_CNT, and it reads 88 when every counter in both rings is hit.
- R5: any_o is 1 exactly when at least one inner counter is accepted.
- R6: multi_o is 1 exactly when at least two inner counters are accepted.
- R7: b2b_o is 1 exactly when two accepted counters i and j exist whose distance (j-i) mod N_CNT lies within N_CNT/2 ± B2B_TOL. With the defaults, offsets 43, 44 and 45 qualify and offset 42 does not.
- R8: The hit vectors presented at clock edge k determine the outputs seen after edge k+2, which is a latency of three register stages. A new result is produced on every clock.
- R9: Hits on the outer ring with no inner hits have no effect: count_o stays 0 and all flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inner_hit_i | input | N_CNT | Discriminated hits of the inner ring, bit i is counter i |
| outer_hit_i | input | N_CNT | Discriminated hits of the outer ring, bit i is counter i |
| count_o | output | $clog2(N_CNT+1) | Number of accepted inner counters |
| any_o | output | 1 | At least one accepted counter |
| multi_o | output | 1 | At least two accepted counters |
| b2b_o | output | 1 | Back-to-back accepted pair present |

## Verification
The hardest case to reach from the ports is a back-to-back pair that sits exactly at the edge of the tolerance window and also straddles the ring seam. Random sparse hits rarely produce one. Directed vectors therefore place accepted counters at offsets 42 to 46 from a base counter, with bases chosen so that the partner index wraps past counter 0. Both outer neighbours are supplied in turn so that each arm of the coincidence is exercised. These directed vectors are followed by back-to-back single-clock patterns and by dense random patterns. That stream shows any pipeline slip and drives the count up to a full ring.

// File: rtl/tof_coinc_pkg.sv
package tof_coinc_pkg;

   // Adder arrangement for the population count.
   typedef enum int {
      POP_FLAT    = 0,
      POP_CHUNKED = 1
   } pop_style_e;

   // Wrapped index on a ring of n counters.
   function automatic int ring_idx(input int i, input int n);
      int r;
      r = i % n;
      if (r < 0) r = r + n;
      return r;
   endfunction

endpackage

// File: rtl/tof_ring_coinc.sv
module tof_ring_coinc #(
   parameter int N_CNT = 88
) (
   input  logic [N_CNT-1:0] inner_i,
   input  logic [N_CNT-1:0] outer_i,
   output logic [N_CNT-1:0] coinc_o
);
   import tof_coinc_pkg::*;

   if (N_CNT < 3) begin : g_bad_ring
      $error("tof_ring_coinc: ring needs at least 3 counters");
   end

   for (genvar g = 0; g < N_CNT; g++) begin : g_cell
      localparam int LO = (g + N_CNT - 1) % N_CNT;
      localparam int HI = (g + 1) % N_CNT;
      assign coinc_o[g] = inner_i[g] & (outer_i[LO] | outer_i[HI]);
   end

endmodule

// File: rtl/tof_popcount.sv
module tof_popcount #(
   parameter int N_BITS = 88,
   parameter int STYLE  = 1,
   parameter int CHUNK  = 8,
   localparam int CW    = $clog2(N_BITS + 1)
) (
   input  logic [N_BITS-1:0] bits_i,
   output logic [CW-1:0]     count_o
);
   import tof_coinc_pkg::*;

   if (CHUNK < 2) begin : g_bad_chunk
      $error("tof_popcount: CHUNK must be at least 2");
   end

   if (STYLE == POP_FLAT) begin : g_flat
      always_comb begin
         count_o = '0;
         for (int i = 0; i < N_BITS; i++)
            count_o = count_o + CW'(bits_i[i]);
      end
   end else begin : g_chunked
      localparam int NCH = (N_BITS + CHUNK - 1) / CHUNK;
      localparam int PW  = $clog2(CHUNK + 1);
      logic [PW-1:0] part [NCH];

      for (genvar c = 0; c < NCH; c++) begin : g_part
         localparam int LO  = c * CHUNK;
         localparam int LEN = ((LO + CHUNK) > N_BITS) ? (N_BITS - LO) : CHUNK;
         always_comb begin
            part[c] = '0;
            for (int j = 0; j < LEN; j++)
               part[c] = part[c] + PW'(bits_i[LO + j]);
         end
      end

      always_comb begin
         count_o = '0;
         for (int c = 0; c < NCH; c++)
            count_o = count_o + CW'(part[c]);
      end
   end

endmodule

// File: rtl/tof_topology.sv
module tof_topology #(
   parameter int N_CNT    = 88,
   parameter int B2B_TOL  = 1
) (
   input  logic [N_CNT-1:0] valid_i,
   output logic             any_o,
   output logic             multi_o,
   output logic             b2b_o
);
   import tof_coinc_pkg::*;

   localparam int HALF = N_CNT / 2;

   if (N_CNT % 2 != 0) begin : g_bad_even
      $error("tof_topology: ring size must be even");
   end
   if (B2B_TOL < 0 || 2 * B2B_TOL >= HALF) begin : g_bad_tol
      $error("tof_topology: back-to-back tolerance out of range");
   end

   logic [N_CNT-1:0] opposite;

   for (genvar g = 0; g < N_CNT; g++) begin : g_opp
      logic [2*B2B_TOL:0] win;
      for (genvar t = 0; t <= 2 * B2B_TOL; t++) begin : g_win
         localparam int IDX = (g + HALF - B2B_TOL + t + N_CNT) % N_CNT;
         assign win[t] = valid_i[IDX];
      end
      assign opposite[g] = valid_i[g] & (|win);
   end

   assign any_o   = |valid_i;
   assign multi_o = |(valid_i & (valid_i - N_CNT'(1)));
   assign b2b_o   = |opposite;

endmodule

// File: rtl/tof_coinc_counter.sv
module tof_coinc_counter #(
   parameter int N_CNT     = 88,
   parameter int B2B_TOL   = 1,
   parameter int POP_STYLE = 1,
   parameter int POP_CHUNK = 8,
   localparam int CW       = $clog2(N_CNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CNT-1:0] inner_hit_i,
   input  logic [N_CNT-1:0] outer_hit_i,
   output logic [CW-1:0]    count_o,
   output logic             any_o,
   output logic             multi_o,
   output logic             b2b_o
);

   // Stage 1: capture raw ring hits.
   logic [N_CNT-1:0] s1_inner, s1_outer;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_inner <= '0;
         s1_outer <= '0;
      end else begin
         s1_inner <= inner_hit_i;
         s1_outer <= outer_hit_i;
      end
   end

   // Stage 2: per-counter coincidence.
   logic [N_CNT-1:0] coinc_c, s2_coinc;
   tof_ring_coinc #(.N_CNT(N_CNT)) u_coinc (
      .inner_i (s1_inner),
      .outer_i (s1_outer),
      .coinc_o (coinc_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_coinc <= '0;
      else        s2_coinc <= coinc_c;
   end

   // R2 / R9: no inner or no outer hits cannot yield coincidences.
   a_r2_no_inner_no_coinc: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_inner == '0) |=> (s2_coinc == '0));
   a_r9_no_outer_no_coinc: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_outer == '0) |=> (s2_coinc == '0));

   // Stage 3: count and topology.
   logic [CW-1:0] cnt_c;
   logic          any_c, multi_c, b2b_c;

   tof_popcount #(.N_BITS(N_CNT), .STYLE(POP_STYLE), .CHUNK(POP_CHUNK)) u_pop (
      .bits_i  (s2_coinc),
      .count_o (cnt_c)
   );

   tof_topology #(.N_CNT(N_CNT), .B2B_TOL(B2B_TOL)) u_topo (
      .valid_i (s2_coinc),
      .any_o   (any_c),
      .multi_o (multi_c),
      .b2b_o   (b2b_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
         any_o   <= 1'b0;
         multi_o <= 1'b0;
         b2b_o   <= 1'b0;
      end else begin
         count_o <= cnt_c;
         any_o   <= any_c;
         multi_o <= multi_c;
         b2b_o   <= b2b_c;
      end
   end

   // Output consistency between the counter and the flag logic.
   a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CW'(N_CNT));
   a_r5_any_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
      any_o == (count_o != '0));
   a_r6_multi_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
      multi_o == (count_o >= CW'(2)));
   a_r7_b2b_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
      b2b_o |-> multi_o);
   a_r8_empty_stage_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_coinc == '0) |=> (count_o == '0));

endmodule

// File: tb/tof_coinc_counter_test.sv
module tof_coinc_counter_test;
   localparam int N  = 88;
   localparam int CW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] inner = '0, outer = '0;
   logic [CW-1:0] count;
   logic any_f, multi_f, b2b_f;

   always #5 clk = ~clk;

   tof_coinc_counter uut (
      .clk(clk), .rst_n(rst_n),
      .inner_hit_i(inner), .outer_hit_i(outer),
      .count_o(count), .any_o(any_f), .multi_o(multi_f), .b2b_o(b2b_f)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   typedef struct {
      int cnt; bit any; bit multi; bit b2b; string tag;
   } exp_t;

   exp_t pipe [3];
   string cur_tag = "R1";

   function automatic exp_t model(input logic [N-1:0] in_h, input logic [N-1:0] out_h, input string tag);
      exp_t e;
      bit v [N];
      e.cnt = 0; e.b2b = 0; e.tag = tag;
      for (int i = 0; i < N; i++) begin
         v[i] = in_h[i] && (out_h[(i + N - 1) % N] || out_h[(i + 1) % N]);
         if (v[i]) e.cnt++;
      end
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            int d;
            d = (j - i + N) % N;
            if (v[i] && v[j] && d >= N/2 - 1 && d <= N/2 + 1) e.b2b = 1;
         end
      e.any = (e.cnt >= 1);
      e.multi = (e.cnt >= 2);
      return e;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference pipeline, three stages deep (R8).
   always @(posedge clk) begin
      if (rst_n) begin
         pipe[2] = pipe[1];
         pipe[1] = pipe[0];
         pipe[0] = model(inner, outer, cur_tag);
      end
   end

   // Compare on every clock, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({"R4 R8 count ", pipe[2].tag}, int'(count), pipe[2].cnt);
         check({"R5 any ", pipe[2].tag}, int'(any_f), int'(pipe[2].any));
         check({"R6 multi ", pipe[2].tag}, int'(multi_f), int'(pipe[2].multi));
         check({"R7 b2b ", pipe[2].tag}, int'(b2b_f), int'(pipe[2].b2b));
      end
   end

   task automatic apply(input logic [N-1:0] in_h, input logic [N-1:0] out_h, input string tag);
      @(negedge clk);
      inner = in_h; outer = out_h; cur_tag = tag;
   endtask

   task automatic flush();
      apply('0, '0, "idle");
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [N-1:0] bit_at(input int i);
      logic [N-1:0] r;
      r = '0;
      r[((i % N) + N) % N] = 1'b1;
      return r;
   endfunction

   // Accepted pair at base and base+off, each with one outer neighbour.
   task automatic pair_at(input int base, input int off, input string tag);
      apply(bit_at(base) | bit_at(base + off),
            bit_at(base + 1) | bit_at(base + off - 1), tag);
      flush();
   endtask

   initial begin
      for (int k = 0; k < 3; k++) pipe[k] = '{0, 0, 0, 0, "R1"};
      repeat (3) @(negedge clk);
      check("R1 reset count", int'(count), 0);
      check("R1 reset flags", int'({any_f, multi_f, b2b_f}), 0);
      @(negedge clk) rst_n = 1'b1;

      // R2: single coincidences through each neighbour.
      apply(bit_at(5), bit_at(6), "R2 upper neighbour");
      apply(bit_at(5), bit_at(4), "R2 lower neighbour");
      apply(bit_at(5), bit_at(5), "R2 same index only");
      apply(bit_at(5), '0, "R2 inner alone");
      flush();
      // R3: wrap at the ring seam.
      apply(bit_at(0), bit_at(N - 1), "R3 zero with last");
      apply(bit_at(N - 1), bit_at(0), "R3 last with zero");
      apply(bit_at(0), bit_at(1), "R3 zero with one");
      flush();
      // R9: outer ring only.
      apply('0, '1, "R9 outer only");
      apply('0, bit_at(7) | bit_at(30), "R9 outer sparse");
      flush();
      // R4: full ring.
      apply('1, '1, "R4 full ring");
      apply('1, '0, "R4 no outer");
      flush();
      // R7: tolerance edges, some across the seam.
      pair_at(10, 44, "R7 offset 44");
      pair_at(10, 43, "R7 offset 43");
      pair_at(10, 45, "R7 offset 45");
      pair_at(10, 42, "R7 offset 42");
      pair_at(10, 46, "R7 offset 46");
      pair_at(60, 44, "R7 wrap 44");
      pair_at(80, 45, "R7 wrap 45");
      pair_at(50, 42, "R7 wrap 42");
      // R8: back-to-back single-clock patterns.
      for (int k = 0; k < 6; k++)
         apply(bit_at(k * 7), bit_at(k * 7 + 1), "R8 streaming");
      flush();
      // Random patterns of varying density.
      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] a, b;
         int dens;
         dens = 2 + (k % 5) * 2;
         for (int i = 0; i < N; i++) begin
            a[i] = ($urandom % dens) == 0;
            b[i] = ($urandom % dens) == 0;
         end
         apply(a, b, "R2 R3 random");
      end
      flush();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule